// File: doc/BRIEF.md
# Lockstep Banked Multiply-Accumulate Array

This block runs a set of identical processing elements in lockstep over a storage array split into independent banks. Each bank holds a fixed number of words, addressed by an element offset. A run consists of a fixed number of passes. In each pass, every element is given its own bank through a per-pass assignment table. It then adds a per-pass signed product `a*b` to every word of that bank, one word per clock. All elements do this on the same cycles and at the same offsets.

Software first fills the assignment and operand tables through a table write port. It can preload or inspect the banks through a host port while the block is idle. It then pulses `start` and waits for `done`. The bank index and operands for a pass are captured when offset 0 of that pass is issued. The read-modify-write takes two register stages. Because the offset advances every cycle, no read reaches a word whose update is still in flight, provided each bank holds at least two words. If the assignment for a pass is illegal, that pass writes nothing and a sticky error flag is raised.

Top module: `lockstep_bank_mac`

## Requirements
- R1: After reset, `busy`, `done` and `err` are low and every bank word reads 0.
- R2: With the block idle, a host write (`host_en`=1, `host_we`=1) stores `host_wdata` at (`host_bank`, `host_addr`). A host read (`host_en`=1, `host_we`=0) returns the word on `host_rdata` in the following cycle.
- R3: A PE's bank index and operands for pass n are taken from the table when offset 0 of pass n is issued, and held for the whole pass. A table write to pass n after that point does not affect pass n. A write to a later pass made before that pass starts does take effect.
- R4: After a run, each word bank[b][i] equals its prior value plus the sum of `a*b` over every pass and PE assigned bank b. Operands are signed two's complement of OP_W bits, the product is sign-extended, and the sum wraps modulo 2^DATA_W.
- R5: `done` is high for exactly one cycle. It rises NUM_PASSES*BANK_WORDS+2 clock edges after the edge that accepts `start`. `busy` is high from the edge after `start` up to that edge, and low while `done` is high.
- R6: A bank index is BIDX_W = clog2(NUM_BANKS)+1 bits wide, and values of NUM_BANKS or more are illegal. A pass in which two PEs share an index, or any index is illegal, writes no word at all, while the other passes still apply. The same condition sets `err`, which stays high until the next accepted `start` clears it.
- R7: Host writes issued while `busy` is high are ignored.
- R8: A `start` pulse while `busy` is high is ignored; the run in progress continues and is not repeated.
- R9: When consecutive passes target the same bank, every update accumulates; no read overtakes a pending write. This requires BANK_WORDS of 2 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted when idle) |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_pass | input | PASS_W | Pass number of the table entry |
| tbl_pe | input | PE_W | PE number of the table entry |
| tbl_bank | input | BIDX_W | Bank index for that PE and pass |
| tbl_a | input | OP_W | Signed operand a |
| tbl_b | input | OP_W | Signed operand b |
| host_en | input | 1 | Host access request |
| host_we | input | 1 | Host access is a write |
| host_bank | input | BANK_W | Host bank select |
| host_addr | input | ELEM_W | Host word offset |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, one cycle after the request |
| busy | output | 1 | Run or pipeline drain in progress |
| done | output | 1 | One-cycle pulse after the last writeback |
| err | output | 1 | Sticky illegal-assignment flag |

## Verification
The bench preloads every word and runs several table sweeps. These include saturating negative operands that force the sums to wrap, and it compares all words against an arithmetic model after each run. A design that read a word before the previous pass's write landed would lose updates when a bank is reused in consecutive passes. A design that reloaded operands mid-pass would pick up a table write made during the run. It also fires an illegal pass with a shared index and one with an out-of-range index. Leaking writes from those passes, failing to flag them, or failing to clear the flag on the next start each show up as wrong words or a wrong `err`. Stray host writes and a second `start` during a run catch a missing idle gate, and the cycle count to `done` catches any extra or missing pipeline stage.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Width of an index over n items, never less than one bit.
    function automatic int unsigned wid(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lbm_sched.sv
module lbm_sched
    import lbm_pkg::*;
#(
    parameter  int NUM_PASSES = 3,
    parameter  int BANK_WORDS = 4,
    localparam int PASS_W     = wid(NUM_PASSES),
    localparam int ELEM_W     = wid(BANK_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              iss_first,
    output logic [PASS_W-1:0] iss_pass,
    output logic              s1_valid,
    output logic [ELEM_W-1:0] s1_elem,
    output logic              s2_valid,
    output logic [ELEM_W-1:0] s2_elem,
    output logic              busy,
    output logic              done,
    output logic              start_acc
);

    localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(NUM_PASSES - 1);
    localparam logic [ELEM_W-1:0] LAST_ELEM = ELEM_W'(BANK_WORDS - 1);

    typedef struct packed {
        run_state_e        st;
        logic [PASS_W-1:0] pass;
        logic [ELEM_W-1:0] elem;
        logic              v1;
        logic [ELEM_W-1:0] e1;
        logic              last1;
        logic              v2;
        logic [ELEM_W-1:0] e2;
        logic              last2;
        logic              done;
    } sched_t;

    sched_t sc_q, sc_d;

    always_comb begin
        sc_d      = sc_q;
        busy      = (sc_q.st == ST_RUN) || sc_q.v1 || sc_q.v2;
        start_acc = start && !busy;

        // pipeline of issued offsets
        sc_d.v1    = (sc_q.st == ST_RUN);
        sc_d.e1    = sc_q.elem;
        sc_d.last1 = (sc_q.st == ST_RUN) && (sc_q.pass == LAST_PASS) && (sc_q.elem == LAST_ELEM);
        sc_d.v2    = sc_q.v1;
        sc_d.e2    = sc_q.e1;
        sc_d.last2 = sc_q.last1;
        sc_d.done  = sc_q.last2;

        unique case (sc_q.st)
            ST_IDLE: begin
                if (start_acc) begin
                    sc_d.st   = ST_RUN;
                    sc_d.pass = '0;
                    sc_d.elem = '0;
                end
            end
            ST_RUN: begin
                if (sc_q.elem == LAST_ELEM) begin
                    sc_d.elem = '0;
                    if (sc_q.pass == LAST_PASS) sc_d.st = ST_IDLE;
                    else                        sc_d.pass = sc_q.pass + 1'b1;
                end else begin
                    sc_d.elem = sc_q.elem + 1'b1;
                end
            end
            default: sc_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sc_q <= '0;
        else        sc_q <= sc_d;
    end

    assign iss_first = (sc_q.st == ST_RUN) && (sc_q.elem == '0);
    assign iss_pass  = sc_q.pass;
    assign s1_valid  = sc_q.v1;
    assign s1_elem   = sc_q.e1;
    assign s2_valid  = sc_q.v2;
    assign s2_elem   = sc_q.e2;
    assign done      = sc_q.done;

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_q.done |=> !sc_q.done);

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_q.done |-> !busy);

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_q.st == ST_RUN && start && sc_q.elem != LAST_ELEM)
            |=> (sc_q.st == ST_RUN && sc_q.elem != '0));

endmodule

// File: rtl/lbm_guard.sv
module lbm_guard #(
    parameter int NUM_PE    = 2,
    parameter int NUM_BANKS = 4,
    parameter int BIDX_W    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_acc,
    input  logic                          first,
    input  logic [NUM_PE-1:0][BIDX_W-1:0] row_idx,
    output logic                          wr_block,
    output logic                          err
);

    typedef struct packed {
        logic bad1;
        logic bad2;
        logic err;
    } guard_t;

    guard_t gd_q, gd_d;
    logic   row_bad;

    always_comb begin
        row_bad = 1'b0;
        for (int p = 0; p < NUM_PE; p++) begin
            if (int'(row_idx[p]) >= NUM_BANKS) row_bad = 1'b1;
            for (int r = p + 1; r < NUM_PE; r++) begin
                if (row_idx[p] == row_idx[r]) row_bad = 1'b1;
            end
        end

        gd_d      = gd_q;
        gd_d.bad1 = first ? row_bad : gd_q.bad1;
        gd_d.bad2 = gd_q.bad1;
        if (start_acc)             gd_d.err = 1'b0;
        else if (first && row_bad) gd_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gd_q <= '0;
        else        gd_q <= gd_d;
    end

    assign wr_block = gd_q.bad2;
    assign err      = gd_q.err;

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gd_q.err && !start_acc) |=> gd_q.err);

endmodule

// File: rtl/lbm_pe.sv
module lbm_pe #(
    parameter int BIDX_W = 3,
    parameter int OP_W   = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              first,
    input  logic [BIDX_W-1:0] tbl_idx,
    input  logic [OP_W-1:0]   tbl_a,
    input  logic [OP_W-1:0]   tbl_b,
    input  logic              s1_mid,
    input  logic [DATA_W-1:0] rd_data,
    output logic [BIDX_W-1:0] rd_idx,
    output logic [BIDX_W-1:0] wr_idx,
    output logic [DATA_W-1:0] wr_data
);

    typedef struct packed {
        logic [BIDX_W-1:0] idx1;
        logic [DATA_W-1:0] prod1;
        logic [BIDX_W-1:0] idx2;
        logic [DATA_W-1:0] sum2;
    } pe_t;

    pe_t                   pe_q, pe_d;
    logic signed [2*OP_W-1:0] mul;

    always_comb begin
        mul   = $signed(tbl_a) * $signed(tbl_b);
        pe_d  = pe_q;
        if (first) begin
            pe_d.idx1  = tbl_idx;
            pe_d.prod1 = DATA_W'(mul);
        end
        pe_d.idx2 = pe_q.idx1;
        pe_d.sum2 = rd_data + pe_q.prod1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pe_q <= '0;
        else        pe_q <= pe_d;
    end

    assign rd_idx  = pe_q.idx1;
    assign wr_idx  = pe_q.idx2;
    assign wr_data = pe_q.sum2;

    // R3
    pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_mid |-> (pe_q.idx1 == $past(pe_q.idx1) && pe_q.prod1 == $past(pe_q.prod1)));

endmodule

// File: rtl/lbm_banks.sv
module lbm_banks #(
    parameter int NUM_PE     = 2,
    parameter int NUM_BANKS  = 4,
    parameter int BANK_WORDS = 4,
    parameter int DATA_W     = 16,
    parameter int BIDX_W     = 3,
    parameter int BANK_W     = 2,
    parameter int ELEM_W     = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          busy,
    input  logic                          rd_valid,
    input  logic [ELEM_W-1:0]             rd_elem,
    input  logic [NUM_PE-1:0][BIDX_W-1:0] rd_idx,
    output logic [NUM_PE-1:0][DATA_W-1:0] rd_data,
    input  logic                          wr_en,
    input  logic [ELEM_W-1:0]             wr_elem,
    input  logic [NUM_PE-1:0][BIDX_W-1:0] wr_idx,
    input  logic [NUM_PE-1:0][DATA_W-1:0] wr_data,
    input  logic                          host_en,
    input  logic                          host_we,
    input  logic [BANK_W-1:0]             host_bank,
    input  logic [ELEM_W-1:0]             host_addr,
    input  logic [DATA_W-1:0]             host_wdata,
    output logic [DATA_W-1:0]             host_rdata
);

    typedef struct packed {
        logic [NUM_BANKS-1:0][BANK_WORDS-1:0][DATA_W-1:0] mem;
        logic [DATA_W-1:0]                                rdata;
    } bank_t;

    bank_t bk_q, bk_d;
    logic  host_wr, host_rd;

    // read crossbar: each PE picks its bank
    always_comb begin
        for (int p = 0; p < NUM_PE; p++) begin
            rd_data[p] = '0;
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (int'(rd_idx[p]) == b) rd_data[p] = bk_q.mem[b][rd_elem];
            end
        end
    end

    always_comb begin
        host_wr = host_en && host_we && !busy;
        host_rd = host_en && !host_we && !busy;
        bk_d    = bk_q;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (int'(host_bank) == b) begin
                if (host_wr) bk_d.mem[b][host_addr] = host_wdata;
                if (host_rd) bk_d.rdata = bk_q.mem[b][host_addr];
            end
        end
        // write crossbar: each bank takes the PE that owns it
        if (wr_en) begin
            for (int p = 0; p < NUM_PE; p++) begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (int'(wr_idx[p]) == b) bk_d.mem[b][wr_elem] = wr_data[p];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign host_rdata = bk_q.rdata;

    // R7
    host_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && wr_en));

    for (genvar p = 0; p < NUM_PE; p++) begin : g_chk_p
        // R6
        wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |-> (int'(wr_idx[p]) < NUM_BANKS));
        for (genvar r = 0; r < NUM_PE; r++) begin : g_chk_r
            if (r != p) begin : g_pair
                // R6
                wr_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    wr_en |-> (wr_idx[p] != wr_idx[r]));
            end
            // R9
            no_raw_hazard_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_valid && wr_en && rd_idx[p] == wr_idx[r]) |-> (rd_elem != wr_elem));
        end
    end

endmodule

// File: rtl/lockstep_bank_mac.sv
module lockstep_bank_mac
    import lbm_pkg::*;
#(
    parameter  int NUM_PE     = 2,
    parameter  int NUM_BANKS  = 4,
    parameter  int BANK_WORDS = 4,
    parameter  int NUM_PASSES = 3,
    parameter  int DATA_W     = 16,
    parameter  int OP_W       = 8,
    localparam int PE_W       = wid(NUM_PE),
    localparam int PASS_W     = wid(NUM_PASSES),
    localparam int BANK_W     = wid(NUM_BANKS),
    localparam int ELEM_W     = wid(BANK_WORDS),
    localparam int BIDX_W     = $clog2(NUM_BANKS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tbl_we,
    input  logic [PASS_W-1:0] tbl_pass,
    input  logic [PE_W-1:0]   tbl_pe,
    input  logic [BIDX_W-1:0] tbl_bank,
    input  logic [OP_W-1:0]   tbl_a,
    input  logic [OP_W-1:0]   tbl_b,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [BANK_W-1:0] host_bank,
    input  logic [ELEM_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              busy,
    output logic              done,
    output logic              err
);

    typedef struct packed {
        logic [NUM_PASSES-1:0][NUM_PE-1:0][BIDX_W-1:0] idx;
        logic [NUM_PASSES-1:0][NUM_PE-1:0][OP_W-1:0]   a;
        logic [NUM_PASSES-1:0][NUM_PE-1:0][OP_W-1:0]   b;
    } table_t;

    table_t tb_q, tb_d;

    logic                          iss_first, s1_valid, s2_valid, start_acc, wr_block, s1_mid;
    logic [PASS_W-1:0]             iss_pass;
    logic [ELEM_W-1:0]             s1_elem, s2_elem;
    logic [NUM_PE-1:0][BIDX_W-1:0] row_idx, rd_idx, wr_idx;
    logic [NUM_PE-1:0][DATA_W-1:0] rd_data, wr_data;

    // assignment and operand tables
    always_comb begin
        tb_d = tb_q;
        if (tbl_we && int'(tbl_pass) < NUM_PASSES && int'(tbl_pe) < NUM_PE) begin
            tb_d.idx[tbl_pass][tbl_pe] = tbl_bank;
            tb_d.a[tbl_pass][tbl_pe]   = tbl_a;
            tb_d.b[tbl_pass][tbl_pe]   = tbl_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    assign row_idx = tb_q.idx[iss_pass];
    assign s1_mid  = s1_valid && (s1_elem != '0);

    lbm_sched #(
        .NUM_PASSES (NUM_PASSES),
        .BANK_WORDS (BANK_WORDS)
    ) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .iss_first (iss_first),
        .iss_pass  (iss_pass),
        .s1_valid  (s1_valid),
        .s1_elem   (s1_elem),
        .s2_valid  (s2_valid),
        .s2_elem   (s2_elem),
        .busy      (busy),
        .done      (done),
        .start_acc (start_acc)
    );

    lbm_guard #(
        .NUM_PE    (NUM_PE),
        .NUM_BANKS (NUM_BANKS),
        .BIDX_W    (BIDX_W)
    ) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_acc (start_acc),
        .first     (iss_first),
        .row_idx   (row_idx),
        .wr_block  (wr_block),
        .err       (err)
    );

    for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
        lbm_pe #(
            .BIDX_W (BIDX_W),
            .OP_W   (OP_W),
            .DATA_W (DATA_W)
        ) u_pe (
            .clk     (clk),
            .rst_n   (rst_n),
            .first   (iss_first),
            .tbl_idx (tb_q.idx[iss_pass][p]),
            .tbl_a   (tb_q.a[iss_pass][p]),
            .tbl_b   (tb_q.b[iss_pass][p]),
            .s1_mid  (s1_mid),
            .rd_data (rd_data[p]),
            .rd_idx  (rd_idx[p]),
            .wr_idx  (wr_idx[p]),
            .wr_data (wr_data[p])
        );
    end

    lbm_banks #(
        .NUM_PE     (NUM_PE),
        .NUM_BANKS  (NUM_BANKS),
        .BANK_WORDS (BANK_WORDS),
        .DATA_W     (DATA_W),
        .BIDX_W     (BIDX_W),
        .BANK_W     (BANK_W),
        .ELEM_W     (ELEM_W)
    ) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .rd_valid   (s1_valid),
        .rd_elem    (s1_elem),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .wr_en      (s2_valid && !wr_block),
        .wr_elem    (s2_elem),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .host_en    (host_en),
        .host_we    (host_we),
        .host_bank  (host_bank),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

endmodule

// File: tb/lockstep_bank_mac_test.sv
module lockstep_bank_mac_test;

    localparam int NP = 2;
    localparam int NB = 4;
    localparam int NL = 4;
    localparam int NN = 3;
    localparam int RUN_LAT = NN * NL + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        tbl_we = 1'b0;
    logic [1:0]  tbl_pass = '0;
    logic [0:0]  tbl_pe = '0;
    logic [2:0]  tbl_bank = '0;
    logic [7:0]  tbl_a = '0;
    logic [7:0]  tbl_b = '0;
    logic        host_en = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_bank = '0;
    logic [1:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        busy, done, err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    int          t_idx [NN][NP];
    int          t_a   [NN][NP];
    int          t_b   [NN][NP];
    logic [15:0] ref_m [NB][NL];

    lockstep_bank_mac uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .tbl_we(tbl_we), .tbl_pass(tbl_pass), .tbl_pe(tbl_pe), .tbl_bank(tbl_bank),
        .tbl_a(tbl_a), .tbl_b(tbl_b),
        .host_en(host_en), .host_we(host_we), .host_bank(host_bank), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .busy(busy), .done(done), .err(err)
    );

    always #5 clk = ~clk;

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got %0d cycles expected fewer than 100000", cyc);
            report();
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive_tbl(input int n, input int p, input int idx, input int a, input int b);
        tbl_we   = 1'b1;
        tbl_pass = 2'(n);
        tbl_pe   = 1'(p);
        tbl_bank = 3'(idx);
        tbl_a    = 8'(a);
        tbl_b    = 8'(b);
    endtask

    task automatic load_table();
        for (int n = 0; n < NN; n++) begin
            for (int p = 0; p < NP; p++) begin
                drive_tbl(n, p, t_idx[n][p], t_a[n][p], t_b[n][p]);
                tick();
            end
        end
        tbl_we = 1'b0;
    endtask

    task automatic host_write(input int b, input int i, input int d);
        host_en = 1'b1; host_we = 1'b1;
        host_bank = 2'(b); host_addr = 2'(i); host_wdata = 16'(d);
        tick();
        host_en = 1'b0; host_we = 1'b0;
    endtask

    task automatic host_read(input int b, input int i, output int d);
        host_en = 1'b1; host_we = 1'b0;
        host_bank = 2'(b); host_addr = 2'(i);
        tick();
        host_en = 1'b0;
        d = int'(host_rdata);
    endtask

    function automatic bit row_ok(input int n);
        for (int p = 0; p < NP; p++) begin
            if (t_idx[n][p] >= NB) return 1'b0;
            for (int r = p + 1; r < NP; r++) if (t_idx[n][p] == t_idx[n][r]) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic model_run();
        for (int n = 0; n < NN; n++) begin
            if (row_ok(n)) begin
                for (int p = 0; p < NP; p++) begin
                    for (int i = 0; i < NL; i++) begin
                        ref_m[t_idx[n][p]][i] = ref_m[t_idx[n][p]][i] + 16'(t_a[n][p] * t_b[n][p]);
                    end
                end
            end
        end
    endtask

    // mode 1 injects a mid-run table change, a host write and a second start
    task automatic do_run(input int mode, output int lat, output int busy_late);
        start = 1'b1;
        tick();
        start = 1'b0;
        lat = -1;
        busy_late = -1;
        for (int k = 1; k <= 60 && lat < 0; k++) begin
            tick();
            tbl_we = 1'b0; host_en = 1'b0; host_we = 1'b0; start = 1'b0;
            if (k == RUN_LAT - 1) busy_late = int'(busy);
            if (done) lat = k;
            if (mode == 1) begin
                case (k)
                    1: drive_tbl(0, 0, 1, 77, 77);
                    2: drive_tbl(2, 1, 1, 50, -3);
                    3: begin
                        host_en = 1'b1; host_we = 1'b1;
                        host_bank = 2'd1; host_addr = 2'd2; host_wdata = 16'h5A5A;
                    end
                    4: start = 1'b1;
                    default: ;
                endcase
            end
        end
        tbl_we = 1'b0; host_en = 1'b0; host_we = 1'b0; start = 1'b0;
    endtask

    task automatic check_all(input string tag);
        int d;
        for (int b = 0; b < NB; b++) begin
            for (int i = 0; i < NL; i++) begin
                host_read(b, i, d);
                chk(tag, d, int'(ref_m[b][i]));
            end
        end
    endtask

    initial begin
        int d, lat, bl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 err", int'(err), 0);
        for (int b = 0; b < NB; b++) begin
            for (int i = 0; i < NL; i++) begin
                host_read(b, i, d);
                chk("R1 word", d, 0);
            end
        end

        // R2: preload every word through the idle host port, read back
        for (int b = 0; b < NB; b++) begin
            for (int i = 0; i < NL; i++) begin
                ref_m[b][i] = 16'(b * 1000 + i * 77 - 1500);
                host_write(b, i, int'(ref_m[b][i]));
            end
        end
        check_all("R2 host readback");

        // Run A: bank 1 reused across consecutive passes (R9), mid-run stimulus (R3 R7 R8)
        t_idx[0][0] = 1; t_idx[0][1] = 3; t_a[0][0] = 3;    t_b[0][0] = 5;   t_a[0][1] = -7; t_b[0][1] = 4;
        t_idx[1][0] = 1; t_idx[1][1] = 0; t_a[1][0] = 12;   t_b[1][0] = -9;  t_a[1][1] = -128; t_b[1][1] = 127;
        t_idx[2][0] = 2; t_idx[2][1] = 1; t_a[2][0] = 100;  t_b[2][0] = 100; t_a[2][1] = -1; t_b[2][1] = -1;
        load_table();
        // pass 2 PE1 rewritten before that pass starts: takes effect; pass 0 rewrite does not
        t_a[2][1] = 50; t_b[2][1] = -3;
        model_run();
        do_run(1, lat, bl);
        chk("R5 latency to done", lat, RUN_LAT);
        chk("R5 busy before done", bl, 1);
        chk("R5 busy low with done", int'(busy), 0);
        chk("R6 err after legal run", int'(err), 0);
        tick();
        chk("R5 done single cycle", int'(done), 0);
        for (int i = 0; i < NL; i++) begin
            host_read(1, i, d);
            chk("R9 reused bank accumulation", d, int'(ref_m[1][i]));
        end
        host_read(1, 2, d);
        chk("R7 host write during run ignored", d, int'(ref_m[1][2]));
        host_read(3, 0, d);
        chk("R3 pass 0 operands held", d, int'(ref_m[3][0]));
        host_read(2, 3, d);
        chk("R3 later pass takes new operands", d, int'(ref_m[2][3]));
        host_read(0, 1, d);
        chk("R8 second start ignored", d, int'(ref_m[0][1]));
        check_all("R4 run A words");
        t_a[0][0] = 77; t_b[0][0] = 77; t_idx[0][0] = 1;

        // R4 sweep: rotating assignments, extreme and mixed-sign operands
        for (int r = 0; r < 4; r++) begin
            for (int n = 0; n < NN; n++) begin
                for (int p = 0; p < NP; p++) begin
                    t_idx[n][p] = (r + n + p * ((r % 2 == 1) ? 1 : 3)) % NB;
                    if (r == 0) begin
                        t_a[n][p] = -128; t_b[n][p] = -128;
                    end else begin
                        t_a[n][p] = ((r * 37 + n * 11 + p * 53) % 256) - 128;
                        t_b[n][p] = ((r * 91 + n * 29 + p * 17) % 256) - 128;
                    end
                end
            end
            load_table();
            model_run();
            do_run(0, lat, bl);
            chk("R5 sweep latency", lat, RUN_LAT);
            check_all("R4 sweep words");
        end

        // R6: pass 1 shares bank 2, pass 2 uses index 5 (out of range)
        t_idx[0][0] = 0; t_idx[0][1] = 3; t_a[0][0] = 9;  t_b[0][0] = 9;  t_a[0][1] = -4; t_b[0][1] = 6;
        t_idx[1][0] = 2; t_idx[1][1] = 2; t_a[1][0] = 11; t_b[1][0] = 13; t_a[1][1] = 5;  t_b[1][1] = 5;
        t_idx[2][0] = 1; t_idx[2][1] = 5; t_a[2][0] = 21; t_b[2][0] = 2;  t_a[2][1] = 7;  t_b[2][1] = 7;
        load_table();
        model_run();
        do_run(0, lat, bl);
        chk("R6 err raised", int'(err), 1);
        tick();
        chk("R6 err sticky", int'(err), 1);
        check_all("R6 illegal passes write nothing");

        // R6: next accepted start clears err
        t_idx[1][1] = 1; t_idx[2][1] = 0;
        load_table();
        model_run();
        start = 1'b1;
        tick();
        start = 1'b0;
        chk("R6 err cleared by start", int'(err), 0);
        for (int k = 0; k < 40 && !done; k++) tick();
        chk("R6 err after legal rerun", int'(err), 0);
        check_all("R4 rerun words");

        report();
    end

endmodule